// File: doc/BRIEF.md
# Half-Precision to Single-Precision Widener

This block takes one 16-bit binary16 floating-point code per clock and produces the 32-bit binary32 code with exactly the same value. It handles every class of input: normal numbers, signed zeros, subnormals, infinities and NaNs. It needs no rounding, because the 32-bit format can hold every 16-bit value.

The datapath has a single register stage. A code presented with `in_valid` high on one rising edge appears on `out_single`, with `out_valid` high, after that edge. Subnormal inputs are renormalized. A leading-one search finds how far the fraction must move so that its top set bit becomes the hidden bit. The exponent is then lowered by the same amount, so the result is always a normal binary32 number.

Top module: `fp16_to_fp32_widen`

## Requirements
- R1: Output bit 31 equals input bit 15 for every input code.
- R2: For an input exponent field (bits 14..10) of 1 to 30, the output exponent (bits 30..23) is the input exponent plus 112. The output fraction bits 22..13 equal input bits 9..0, and output bits 12..0 are zero.
- R3: For an input exponent field of 31, the output exponent is 255. Input fraction bits 9..0 appear at output bits 22..13 and output bits 12..0 are zero, so infinities stay infinities and NaN payloads are kept.
- R4: When input bits 14..0 are all zero, output bits 30..0 are all zero.
- R5: For an input exponent of 0 with a nonzero fraction, let p be the position of the fraction's highest set bit (0 to 9). The output exponent is p+103. The output fraction holds the fraction bits below position p, left-aligned in bits 22..0, with zeros below them. The value is therefore fraction times 2^-24 and is exact.
- R6: `out_valid` on a rising edge takes the value `in_valid` had just before that edge. The output data is updated on that same edge when `in_valid` is high.
- R7: When `in_valid` is low on an edge, `out_single` keeps its previous value.
- R8: While `rst` is high on a rising edge, `out_valid` and `out_single` are cleared to zero, and any `in_valid` on that edge is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks `in_half` as a code to convert |
| in_half | input | 16 | binary16 input code |
| out_valid | output | 1 | Marks `out_single` as a fresh result |
| out_single | output | 32 | binary32 result, registered |

## Verification
The rarest situations are subnormal inputs whose only set bit sits at a particular fraction position, since each needs a different shift. The largest shift, ten places for a fraction of one, is the hardest case. Random values seldom land on these. The bench therefore streams every one of the 65536 input codes back to back, which reaches each shift amount, both signs of zero and every NaN payload. It compares each result with a reference that finds the leading one by scanning the fraction.

// File: rtl/fpw_pkg.sv
package fpw_pkg;

    // binary16 layout
    localparam int H_EXP_W  = 5;
    localparam int H_FRAC_W = 10;
    localparam int H_W      = 1 + H_EXP_W + H_FRAC_W;

    // binary32 layout
    localparam int S_EXP_W  = 8;
    localparam int S_FRAC_W = 23;
    localparam int S_W      = 1 + S_EXP_W + S_FRAC_W;

    // Derived constants
    localparam int H_BIAS     = (1 << (H_EXP_W - 1)) - 1;
    localparam int S_BIAS     = (1 << (S_EXP_W - 1)) - 1;
    localparam int BIAS_DELTA = S_BIAS - H_BIAS;
    localparam int FRAC_PAD   = S_FRAC_W - H_FRAC_W;
    localparam int SHIFT_W    = $clog2(H_FRAC_W + 1);

    typedef struct packed {
        logic                sign;
        logic [H_EXP_W-1:0]  exp;
        logic [H_FRAC_W-1:0] frac;
    } half_t;

    typedef struct packed {
        logic                sign;
        logic [S_EXP_W-1:0]  exp;
        logic [S_FRAC_W-1:0] frac;
    } single_t;

    typedef enum logic [1:0] {
        CLS_ZERO    = 2'd0,
        CLS_SUBNORM = 2'd1,
        CLS_NORMAL  = 2'd2,
        CLS_SPECIAL = 2'd3
    } hclass_t;

    function automatic hclass_t classify_half(half_t h);
        if (h.exp == '1)
            return CLS_SPECIAL;
        else if (h.exp != '0)
            return CLS_NORMAL;
        else if (h.frac != '0)
            return CLS_SUBNORM;
        else
            return CLS_ZERO;
    endfunction

endpackage

// File: rtl/fpw_lead_shift.sv
// Priority encoder: shift distance that moves the highest set bit of vec
// just past the top of the field (1 for bit W-1, W for bit 0).
module fpw_lead_shift #(
    parameter int W  = 10,
    parameter int SW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [SW-1:0] shift
);
    always_comb begin
        shift = '0;
        for (int i = 0; i < W; i++) begin
            if (vec[i])
                shift = SW'(W - i);
        end
    end
endmodule

// File: rtl/fpw_assemble.sv
module fpw_assemble
    import fpw_pkg::*;
(
    input  half_t                h,
    input  hclass_t              cls,
    input  logic [SHIFT_W-1:0]   shift,
    output single_t              s
);
    logic [H_FRAC_W-1:0] renorm_frac;

    assign renorm_frac = h.frac << shift;

    always_comb begin
        s.sign = h.sign;
        unique case (cls)
            CLS_NORMAL: begin
                s.exp  = S_EXP_W'(h.exp) + S_EXP_W'(BIAS_DELTA);
                s.frac = {h.frac, {FRAC_PAD{1'b0}}};
            end
            CLS_SUBNORM: begin
                s.exp  = S_EXP_W'(BIAS_DELTA + 1) - S_EXP_W'(shift);
                s.frac = {renorm_frac, {FRAC_PAD{1'b0}}};
            end
            CLS_SPECIAL: begin
                s.exp  = '1;
                s.frac = {h.frac, {FRAC_PAD{1'b0}}};
            end
            default: begin
                s.exp  = '0;
                s.frac = '0;
            end
        endcase
    end
endmodule

// File: rtl/fp16_to_fp32_widen.sv
module fp16_to_fp32_widen
    import fpw_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [H_W-1:0] in_half,
    output logic           out_valid,
    output logic [S_W-1:0] out_single
);
    half_t              h_in;
    hclass_t            h_cls;
    logic [SHIFT_W-1:0] lead_shift;
    single_t            s_next;
    single_t            s_q;

    assign h_in  = half_t'(in_half);
    assign h_cls = classify_half(h_in);

    fpw_lead_shift #(
        .W  (H_FRAC_W),
        .SW (SHIFT_W)
    ) u_lead (
        .vec   (h_in.frac),
        .shift (lead_shift)
    );

    fpw_assemble u_asm (
        .h     (h_in),
        .cls   (h_cls),
        .shift (lead_shift),
        .s     (s_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            s_q       <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                s_q <= s_next;
        end
    end

    assign out_single = s_q;
endmodule

// File: rtl/fpw_checker.sv
module fpw_checker (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [15:0] in_half,
    input logic        out_valid,
    input logic [31:0] out_single
);
    assert_valid_follows_R6: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_follows_R6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_single));

    assert_sign_copy_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_single[31] == $past(in_half[15]));

    assert_special_exp_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_half[14:10] == 5'h1f) |=> out_single[30:23] == 8'hff);

    assert_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_half[14:0] == 15'd0) |=> out_single[30:0] == 31'd0);

    assert_subnorm_range_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_half[14:10] == 5'd0 && in_half[9:0] != 10'd0)
        |=> (out_single[30:23] >= 8'd103 && out_single[30:23] <= 8'd112));

    assert_normal_frac_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_half[14:10] != 5'd0 && in_half[14:10] != 5'h1f)
        |=> out_single[22:13] == $past(in_half[9:0]) && out_single[12:0] == 13'd0);
endmodule

bind fp16_to_fp32_widen fpw_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_half    (in_half),
    .out_valid  (out_valid),
    .out_single (out_single)
);

// File: tb/fp16_to_fp32_widen_tb.sv
`timescale 1ns/1ps
module fp16_to_fp32_widen_tb;

    localparam real PERIOD = 8.0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_half = 16'd0;
    logic        out_valid;
    logic [31:0] out_single;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(PERIOD / 2.0) clk = ~clk;

    fp16_to_fp32_widen u_dut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_half    (in_half),
        .out_valid  (out_valid),
        .out_single (out_single)
    );

    // Reference: decode the class, find the leading one by scanning.
    function automatic logic [31:0] ref_model(input logic [15:0] h);
        logic [4:0]  e;
        logic [9:0]  f;
        logic [7:0]  oe;
        logic [22:0] of_;
        int          p;
        e = h[14:10];
        f = h[9:0];
        if (e == 5'h1f) begin
            oe  = 8'hff;
            of_ = {f, 13'd0};
        end else if (e != 0) begin
            oe  = 8'(int'(e) + 112);
            of_ = {f, 13'd0};
        end else if (f == 0) begin
            oe  = 8'd0;
            of_ = 23'd0;
        end else begin
            p = 0;
            for (int k = 9; k >= 0; k--) begin
                if (f[k]) begin
                    p = k;
                    break;
                end
            end
            oe  = 8'(p + 103);
            of_ = 23'((int'(f) - (1 << p)) << (23 - p));
        end
        return {h[15], oe, of_};
    endfunction

    function automatic string tag_of(input logic [15:0] h);
        if (h[14:10] == 5'h1f) return "R3";
        if (h[14:10] != 0)     return "R2";
        if (h[9:0] == 0)       return "R4";
        return "R5";
    endfunction

    task automatic check32(input string tag, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    initial begin : watchdog
        #(PERIOD * 200000.0);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0] prev;
        prev = 16'd0;

        // R8: reset state, with a valid strobe present during reset
        in_valid = 1'b1;
        in_half  = 16'h3c00;
        repeat (3) @(negedge clk);
        check32("R8", "out_valid in reset", {31'd0, out_valid}, 32'd0);
        check32("R8", "out_single in reset", out_single, 32'd0);
        in_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;

        // Exhaustive back-to-back sweep (R1..R6)
        for (int i = 0; i <= 65536; i++) begin
            @(negedge clk);
            if (i > 0) begin
                check32("R6", "out_valid", {31'd0, out_valid}, 32'd1);
                check32(tag_of(prev), "value", out_single, ref_model(prev));
                check32("R1", "sign", {31'd0, out_single[31]}, {31'd0, prev[15]});
            end
            if (i < 65536) begin
                prev     = 16'(i);
                in_half  = 16'(i);
                in_valid = 1'b1;
            end else begin
                in_valid = 1'b0;
                in_half  = 16'h3c00;
            end
        end

        // R7: idle cycles keep last value (0xffff is a negative NaN)
        @(negedge clk);
        check32("R6", "out_valid idle", {31'd0, out_valid}, 32'd0);
        check32("R7", "hold", out_single, 32'hffffe000);

        // Spot values: R5 smallest subnormal (shift of ten)
        in_valid = 1'b1;
        in_half  = 16'h0001;
        @(negedge clk);
        in_valid = 1'b0;
        check32("R5", "min subnormal", out_single, 32'h33800000);
        // R4 negative zero
        in_valid = 1'b1;
        in_half  = 16'h8000;
        @(negedge clk);
        in_valid = 1'b0;
        check32("R4", "negative zero", out_single, 32'h80000000);
        // R2 one
        in_valid = 1'b1;
        in_half  = 16'h3c00;
        @(negedge clk);
        in_valid = 1'b0;
        in_half  = 16'h7c00;
        check32("R2", "one", out_single, 32'h3f800000);
        @(negedge clk);
        check32("R7", "hold after spot", out_single, 32'h3f800000);

        // R8: reset mid-run clears outputs
        rst = 1'b1;
        in_valid = 1'b1;
        @(negedge clk);
        check32("R8", "out_valid after reset", {31'd0, out_valid}, 32'd0);
        check32("R8", "out_single after reset", out_single, 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule